// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns a column command into the column address of every beat of a memory burst. A small mode register sets the burst length (1, 2, 4 or 8 beats, or a whole 512-column page), the beat order (sequential or interleaved) and a CAS latency value. The latency value is only held and passed on to the data-path timing logic. When a read or write command arrives with its starting column, the block emits one column per clock. It raises a flag on the final beat of a fixed-length burst.

A new command may cut into a running burst on any clock, and the sequence restarts from the new column. A stop input ends the burst early. A page burst runs through the page and wraps until it is stopped. Mode settings that the beat logic cannot honour are flagged, and commands issued under them are dropped. Each burst keeps the length and order that were in force when its command arrived.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, beat_valid, last_beat, col, cas_lat and mode_illegal are all 0, and the mode register holds 0 (single-beat, sequential).
- R2: A mode_wr pulse loads mode_val into the mode register at the clock edge. Bits 2:0 hold the length code: 0, 1, 2 and 3 select 1, 2, 4 and 8 beats, and 7 selects a full page. Bit 3 holds the order: 0 is sequential, 1 is interleaved. Bits 6:4 are the latency, which appears on cas_lat one cycle after the write.
- R3: A cmd_start under a legal mode puts the first beat on the outputs in the next cycle, with beat_valid high and col equal to start_col. One further beat follows on each later clock.
- R4: In sequential order with length BL, beat k carries the upper bits of start_col unchanged. Its low log2(BL) bits are (start_col + k) mod BL.
- R5: In interleaved order, beat k carries start_col XOR k.
- R6: In full-page mode, beat k carries (start_col + k) mod 512. The burst continues past 512 beats, and last_beat stays low throughout.
- R7: last_beat is high on beat BL-1 of a fixed-length burst and low on every other beat. beat_valid is low in the cycle after the last beat unless a new command was accepted.
- R8: A stop without a cmd_start drops beat_valid in the next cycle. When stop and a legal cmd_start arrive together, the command wins.
- R9: A legal cmd_start during a burst restarts the sequence in the next cycle from the new column at beat 0.
- R10: mode_illegal is high when the length code is 4, 5 or 6, or when the code is 7 with interleaved order. While it is high, cmd_start is ignored: no burst starts, and a burst already running continues unchanged.
- R11: col is 0 whenever beat_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Load mode_val into the mode register |
| mode_val | input | 7 | Mode value: latency[6:4], order[3], length code[2:0] |
| cmd_start | input | 1 | Read or write column command |
| start_col | input | 9 | Starting column of the command |
| stop | input | 1 | Burst-stop command |
| col | output | 9 | Column of the current beat |
| beat_valid | output | 1 | A beat is being issued this cycle |
| last_beat | output | 1 | Current beat is the last of a fixed-length burst |
| cas_lat | output | 3 | Latency field of the mode register |
| mode_illegal | output | 1 | Current mode cannot be sequenced |

## Verification
Beat 0 appears exactly one cycle after the command cycle. Beat k appears k cycles after beat 0, and cas_lat and mode_illegal follow a mode write by one cycle. The effect of a stop, an interrupt or an ignored command shows one cycle after that input. The bench changes inputs on falling edges and reads outputs on the next falling edge, so every sample falls half a period after the register stage has updated. The sweep covers every start column under each fixed length and both orders. It checks each beat and the idle cycle that follows the burst.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [6:0]       mode_val,
  input  logic             cmd_start,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop,
  output logic [COL_W-1:0] col,
  output logic             beat_valid,
  output logic             last_beat,
  output logic [2:0]       cas_lat,
  output logic             mode_illegal
);

  localparam logic [2:0] PAGE_CODE = 3'd7;

  logic [6:0]       mode_q;
  logic             active_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] idx_q;
  logic [1:0]       lg_q;
  logic             ilv_q;
  logic             page_q;

  wire [2:0] len_code = mode_q[2:0];
  wire       ilv_sel  = mode_q[3];
  wire       page_sel = (len_code == PAGE_CODE);
  wire       accept;

  assign mode_illegal = (len_code[2] & ~page_sel) | (page_sel & ilv_sel);
  assign cas_lat      = mode_q[6:4];
  assign accept       = cmd_start & ~mode_illegal;

  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] ilv_col;

  assign mask    = page_q ? '1 : ((COL_W'(1) << lg_q) - COL_W'(1));
  assign seq_col = (base_q & ~mask) | ((base_q + idx_q) & mask);
  assign ilv_col = base_q ^ idx_q;

  assign beat_valid = active_q;
  assign col        = active_q ? (ilv_q ? ilv_col : seq_col) : '0;
  assign last_beat  = active_q & ~page_q & (idx_q == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_wr) begin
      mode_q <= mode_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      idx_q    <= '0;
      lg_q     <= '0;
      ilv_q    <= 1'b0;
      page_q   <= 1'b0;
    end else if (accept) begin
      active_q <= 1'b1;
      base_q   <= start_col;
      idx_q    <= '0;
      lg_q     <= len_code[1:0];
      ilv_q    <= ilv_sel;
      page_q   <= page_sel;
    end else if (stop) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      if (last_beat) active_q <= 1'b0;
      else           idx_q    <= idx_q + COL_W'(1);
    end
  end

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_wr,
  input logic [6:0]       mode_val,
  input logic             cmd_start,
  input logic [COL_W-1:0] start_col,
  input logic             stop,
  input logic [COL_W-1:0] col,
  input logic             beat_valid,
  input logic             last_beat,
  input logic [2:0]       cas_lat,
  input logic             mode_illegal
);

  assert_latency_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> cas_lat == $past(mode_val[6:4]));

  assert_first_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !mode_illegal) |=> (beat_valid && col == $past(start_col)));

  assert_last_is_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> beat_valid);

  assert_end_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !(cmd_start && !mode_illegal)) |=> !beat_valid);

  assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !cmd_start) |=> !beat_valid);

  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat_valid && !(cmd_start && !mode_illegal)) |=> !beat_valid);

  assert_idle_col_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_valid |-> col == '0);

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/burst_col_seq_test.sv
`timescale 1ns/1ps
module burst_col_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_wr = 1'b0;
  logic [6:0] mode_val = '0;
  logic       cmd_start = 1'b0;
  logic [8:0] start_col = '0;
  logic       stop = 1'b0;
  logic [8:0] col;
  logic       beat_valid, last_beat, mode_illegal;
  logic [2:0] cas_lat;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  burst_col_seq uut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_val(mode_val),
    .cmd_start(cmd_start), .start_col(start_col), .stop(stop),
    .col(col), .beat_valid(beat_valid), .last_beat(last_beat),
    .cas_lat(cas_lat), .mode_illegal(mode_illegal)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_col(input int s, input int k, input int lg, input bit ilv, input bit page);
    int m;
    if (page) return (s + k) % 512;
    if (ilv) return s ^ k;
    m = (1 << lg) - 1;
    return (s & ~m) | ((s + k) & m);
  endfunction

  task automatic set_mode(input logic [6:0] v);
    @(negedge clk); mode_wr = 1'b1; mode_val = v;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic issue(input int s);
    @(negedge clk); cmd_start = 1'b1; start_col = 9'(s);
    @(negedge clk); cmd_start = 1'b0;
  endtask

  task automatic run_burst(input int s, input int lg, input bit ilv);
    int bl;
    bl = 1 << lg;
    issue(s);
    for (int k = 0; k < bl; k++) begin
      chk(ilv ? "R5 valid" : "R3 valid", beat_valid, 1);
      chk(ilv ? "R5 interleaved col" : "R4 sequential col", col, exp_col(s, k, lg, ilv, 0));
      chk("R7 last flag", last_beat, (k == bl - 1) ? 1 : 0);
      @(negedge clk);
    end
    chk("R7 idle after last", beat_valid, 0);
    chk("R11 idle col", col, 0);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", beat_valid, 0);
    chk("R1 last", last_beat, 0);
    chk("R1 col", col, 0);
    chk("R1 cas_lat", cas_lat, 0);
    chk("R1 illegal", mode_illegal, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", beat_valid, 0);
    run_burst(37, 0, 0);

    for (int lg = 0; lg < 4; lg++)
      for (int il = 0; il < 2; il++) begin
        set_mode({3'(lg + 2), il[0], 3'(lg)});
        chk("R2 cas_lat", cas_lat, lg + 2);
        chk("R2 legal", mode_illegal, 0);
        for (int s = 0; s < 512; s++) run_burst(s, lg, il[0]);
      end

    set_mode(7'b101_0_111);
    chk("R2 page latency", cas_lat, 5);
    chk("R10 page seq legal", mode_illegal, 0);
    issue(509);
    for (int k = 0; k < 600; k++) begin
      chk("R6 page valid", beat_valid, 1);
      chk("R6 page col", col, exp_col(509, k, 0, 0, 1));
      chk("R6 page never last", last_beat, 0);
      @(negedge clk);
    end
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    chk("R8 stop page", beat_valid, 0);
    chk("R11 col after stop", col, 0);

    set_mode(7'b011_0_011);
    issue(5);
    @(negedge clk); @(negedge clk);
    chk("R9 pre-interrupt col", col, exp_col(5, 2, 3, 0, 0));
    cmd_start = 1'b1; start_col = 9'd100;
    @(negedge clk); cmd_start = 1'b0;
    for (int k = 0; k < 8; k++) begin
      chk("R9 restart col", col, exp_col(100, k, 3, 0, 0));
      chk("R9 restart last", last_beat, (k == 7) ? 1 : 0);
      @(negedge clk);
    end
    chk("R9 end", beat_valid, 0);

    issue(200);
    @(negedge clk);
    stop = 1'b1; cmd_start = 1'b1; start_col = 9'd300;
    @(negedge clk); stop = 1'b0; cmd_start = 1'b0;
    chk("R8 start beats stop valid", beat_valid, 1);
    chk("R8 start beats stop col", col, 300);
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    chk("R8 stop mid burst", beat_valid, 0);

    for (int c = 4; c < 8; c++) begin
      set_mode({3'd2, (c == 7) ? 1'b1 : 1'b0, 3'(c)});
      chk("R10 illegal flag", mode_illegal, 1);
      issue(10);
      chk("R10 ignored command", beat_valid, 0);
      chk("R11 col idle", col, 0);
    end

    set_mode(7'b010_1_010);
    issue(6);
    chk("R5 first beat", col, 6);
    @(negedge clk); mode_wr = 1'b1; mode_val = 7'b010_1_111;
    @(negedge clk); mode_wr = 1'b0;
    chk("R5 beat 2 under new mode", col, 6 ^ 2);
    cmd_start = 1'b1; start_col = 9'd50;
    @(negedge clk); cmd_start = 1'b0;
    chk("R10 burst continues col", col, 6 ^ 3);
    chk("R10 burst continues last", last_beat, 1);
    @(negedge clk);
    chk("R10 no restart", beat_valid, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule